// File: doc/BRIEF.md
# Answer-to-Reset Early Answer Detector

This block watches a smart-card I/O line after every change of the card reset line and flags a card that starts its answer-to-reset too soon. It runs on the card clock. Both the reset level and the I/O line are brought into that clock domain through a short synchronizer. Each change of the reset level, rising or falling, restarts a cycle counter and arms the detector.

Falling edges on I/O during an initial blanking interval are discarded. The first falling edge (start bit) at or after the blanking limit decides the outcome. If it falls inside the early window, a sticky flag is raised. The flag drives an active-low interrupt request and stays set until a status read clears it. If the window passes without a start bit, the detector disarms and waits for the next reset change. The counter saturates one count past the window, so it can never wrap back into the window.

Top module: `atr_early_detect`

## Requirements
- R1: Edges are numbered from the card-clock edge that first samples a new `card_rst` level, which is edge 0. The first `io_in` high-to-low transition first sampled at edge k sets `early_flag` when 200 <= k <= 384 (defaults `BLANK_CLKS`, `WIN_LAST`). The flag is visible after edge k+2.
- R2: Falling edges with k < 200 never set the flag. They also do not disarm the detector, so a later falling edge inside the window still sets it.
- R3: Every `card_rst` change, in either direction, restarts the edge count and re-arms the detector. Counting from an earlier change is discarded.
- R4: `irq_n` is low exactly while `early_flag` is high.
- R5: A `status_rd` high at a clock edge clears `early_flag` at that edge. If a window hit occurs at the same edge, the flag stays set.
- R6: Only the first falling edge at or after the blanking limit counts. After that edge, further falling edges before the next `card_rst` change have no effect, even when the flag has been cleared in between.
- R7: Falling edges with k > 384 never set the flag. This holds however long after the change they arrive, so there is no counter wrap (for example, k = 712 does not set it).
- R8: After `rst_n` is released, `early_flag` is 0 and `irq_n` is 1. The detector stays disarmed until the first `card_rst` change.
- R9: Only a high-to-low transition counts as a start bit. An `io_in` held low across a `card_rst` change and through the whole window does not set the flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Card clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| card_rst | input | 1 | Card reset line level (asynchronous) |
| io_in | input | 1 | Card I/O line level (asynchronous), idle high |
| status_rd | input | 1 | Status read strobe; clears the flag |
| early_flag | output | 1 | Sticky early-answer flag |
| irq_n | output | 1 | Active-low interrupt request from the flag |

## Verification
Some properties are checked by assertions on every cycle. A reset change reloads the counter. The counter stays at its saturation value until the next change. The flag only rises when the counter was inside the window. A set flag holds without a read and drops after a read. The interrupt follows the flag. The scenarios cover the rest, since these depend on where I/O edges fall relative to reset changes: both window limits, blanking edges that must not disarm, ignoring later edges after a clear, re-arming mid-window, a level held low, and very late edges.

// File: rtl/atr_pkg.sv
package atr_pkg;
  // Conditioned events from one synchronized input line
  typedef struct packed {
    logic lvl;      // synchronized level
    logic fell;     // high-to-low seen this cycle
    logic changed;  // any change seen this cycle
  } atr_evt_t;
endpackage

// File: rtl/atr_rst_sync.sv
module atr_rst_sync (
  input  logic clk,
  input  logic arst_n,
  output logic rst_n_sync
);
  logic [1:0] sh_q;
  logic [1:0] sh_d;

  always_comb begin
    sh_d = {sh_q[0], 1'b1};
  end

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) sh_q <= 2'b00;
    else         sh_q <= sh_d;
  end

  assign rst_n_sync = sh_q[1];
endmodule

// File: rtl/atr_in_cond.sv
module atr_in_cond
  import atr_pkg::*;
#(
  parameter int unsigned STAGES  = 2,
  parameter logic        RST_VAL = 1'b0
) (
  input  logic     clk,
  input  logic     rst_n,
  input  logic     d_async,
  output atr_evt_t evt
);
  localparam int unsigned DEPTH = STAGES + 1;

  logic [DEPTH-1:0] pipe_q;
  logic [DEPTH-1:0] pipe_d;

  generate
    for (genvar g = 0; g < DEPTH; g++) begin : g_stage
      if (g == 0) begin : g_first
        always_comb pipe_d[g] = d_async;
      end else begin : g_next
        always_comb pipe_d[g] = pipe_q[g-1];
      end
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pipe_q[g] <= RST_VAL;
        else        pipe_q[g] <= pipe_d[g];
      end
    end
  endgenerate

  always_comb begin
    evt.lvl     = pipe_q[STAGES-1];
    evt.fell    = pipe_q[STAGES] & ~pipe_q[STAGES-1];
    evt.changed = pipe_q[STAGES] ^ pipe_q[STAGES-1];
  end
endmodule

// File: rtl/atr_cycle_cnt.sv
module atr_cycle_cnt #(
  parameter int unsigned CNT_W   = 9,
  parameter int unsigned SAT_CNT = 385
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             restart,
  output logic [CNT_W-1:0] cnt_q
);
  localparam logic [CNT_W-1:0] SAT_V = CNT_W'(SAT_CNT);
  localparam logic [CNT_W-1:0] ONE_V = CNT_W'(1);

  logic [CNT_W-1:0] cnt_d;
  logic             cnt_en;

  always_comb begin
    cnt_en = restart | (cnt_q != SAT_V);
    if (restart) cnt_d = ONE_V;
    else         cnt_d = cnt_q + ONE_V;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= SAT_V;
    else if (cnt_en) cnt_q <= cnt_d;
  end
endmodule

// File: rtl/atr_flag_ctl.sv
module atr_flag_ctl #(
  parameter int unsigned CNT_W      = 9,
  parameter int unsigned BLANK_CLKS = 200,
  parameter int unsigned WIN_LAST   = 384
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             restart,
  input  logic             io_fell,
  input  logic [CNT_W-1:0] cnt,
  input  logic             clr,
  output logic             win_hit,
  output logic             armed_q,
  output logic             flag_q
);
  localparam logic [CNT_W-1:0] BLANK_V = CNT_W'(BLANK_CLKS);
  localparam logic [CNT_W-1:0] LAST_V  = CNT_W'(WIN_LAST);

  logic past_blank;
  logic in_win;
  logic armed_d, armed_en;
  logic flag_d, flag_en;

  always_comb begin
    past_blank = (cnt >= BLANK_V);
    in_win     = past_blank && (cnt <= LAST_V);
    win_hit    = armed_q && !restart && io_fell && in_win;

    armed_en = restart | (armed_q & ((io_fell & past_blank) | !in_win & past_blank));
    armed_d  = restart;

    flag_en = win_hit | clr;
    flag_d  = win_hit;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        armed_q <= 1'b0;
    else if (armed_en) armed_q <= armed_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       flag_q <= 1'b0;
    else if (flag_en) flag_q <= flag_d;
  end
endmodule

// File: rtl/atr_early_detect.sv
module atr_early_detect
  import atr_pkg::*;
#(
  parameter int unsigned BLANK_CLKS  = 200,
  parameter int unsigned WIN_LAST    = 384,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic card_rst,
  input  logic io_in,
  input  logic status_rd,
  output logic early_flag,
  output logic irq_n
);
  localparam int unsigned SAT_CNT = WIN_LAST + 1;
  localparam int unsigned CNT_W   = $clog2(SAT_CNT + 1);

  logic             rst_sync_n;
  atr_evt_t         rst_evt;
  atr_evt_t         io_evt;
  logic [CNT_W-1:0] cnt_q;
  logic             win_hit;
  logic             armed_q;

  atr_rst_sync u_rst_sync (
    .clk        (clk),
    .arst_n     (rst_n),
    .rst_n_sync (rst_sync_n)
  );

  atr_in_cond #(.STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_rst_cond (
    .clk     (clk),
    .rst_n   (rst_sync_n),
    .d_async (card_rst),
    .evt     (rst_evt)
  );

  atr_in_cond #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_io_cond (
    .clk     (clk),
    .rst_n   (rst_sync_n),
    .d_async (io_in),
    .evt     (io_evt)
  );

  atr_cycle_cnt #(.CNT_W(CNT_W), .SAT_CNT(SAT_CNT)) u_cnt (
    .clk     (clk),
    .rst_n   (rst_sync_n),
    .restart (rst_evt.changed),
    .cnt_q   (cnt_q)
  );

  atr_flag_ctl #(
    .CNT_W      (CNT_W),
    .BLANK_CLKS (BLANK_CLKS),
    .WIN_LAST   (WIN_LAST)
  ) u_flag (
    .clk     (clk),
    .rst_n   (rst_sync_n),
    .restart (rst_evt.changed),
    .io_fell (io_evt.fell),
    .cnt     (cnt_q),
    .clr     (status_rd),
    .win_hit (win_hit),
    .armed_q (armed_q),
    .flag_q  (early_flag)
  );

  assign irq_n = ~early_flag;
endmodule

// File: rtl/atr_early_detect_chk.sv
module atr_early_detect_chk #(
  parameter int unsigned CNT_W      = 9,
  parameter int unsigned BLANK_CLKS = 200,
  parameter int unsigned WIN_LAST   = 384
) (
  input logic             clk,
  input logic             rst_n,
  input logic             restart,
  input logic [CNT_W-1:0] cnt,
  input logic             win_hit,
  input logic             status_rd,
  input logic             early_flag,
  input logic             irq_n
);
  localparam logic [CNT_W-1:0] BLANK_V = CNT_W'(BLANK_CLKS);
  localparam logic [CNT_W-1:0] LAST_V  = CNT_W'(WIN_LAST);
  localparam logic [CNT_W-1:0] SAT_V   = CNT_W'(WIN_LAST + 1);

  assert_rise_in_window_R1: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(early_flag) |-> ($past(cnt) >= BLANK_V && $past(cnt) <= LAST_V));

  assert_restart_count_R3: assert property (@(posedge clk) disable iff (!rst_n)
    restart |=> (cnt == CNT_W'(1)));

  assert_irq_follows_R4: assert property (@(posedge clk) disable iff (!rst_n)
    early_flag |-> !irq_n);

  assert_read_clears_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (early_flag && status_rd && !win_hit) |=> !early_flag);

  assert_sticky_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (early_flag && !status_rd) |=> early_flag);

  assert_no_wrap_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt == SAT_V && !restart) |=> (cnt == SAT_V));

  assert_bounded_R7: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= SAT_V);
endmodule

bind atr_early_detect atr_early_detect_chk #(
  .CNT_W      (CNT_W),
  .BLANK_CLKS (BLANK_CLKS),
  .WIN_LAST   (WIN_LAST)
) chk_i (
  .clk        (clk),
  .rst_n      (rst_sync_n),
  .restart    (rst_evt.changed),
  .cnt        (cnt_q),
  .win_hit    (win_hit),
  .status_rd  (status_rd),
  .early_flag (early_flag),
  .irq_n      (irq_n)
);

// File: tb/atr_early_detect_tb_top.sv
module atr_early_detect_tb_top;
  localparam int unsigned BLANK = 200;
  localparam int unsigned LAST  = 384;

  logic clk = 1'b0;
  logic rst_n, card_rst, io_in, status_rd;
  logic early_flag, irq_n;
  int   checks = 0;
  int   errors = 0;

  always #5 clk = ~clk;

  atr_early_detect dut_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .card_rst   (card_rst),
    .io_in      (io_in),
    .status_rd  (status_rd),
    .early_flag (early_flag),
    .irq_n      (irq_n)
  );

  function automatic logic exp_hit(input int k);
    return (k >= int'(BLANK)) && (k <= int'(LAST));
  endfunction

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input string req, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0b expected=%0b", req, act, exp);
    end
  endtask

  task automatic toggle_rst();
    card_rst = ~card_rst;
  endtask

  task automatic io_pulse();
    io_in = 1'b0;
    tick(3);
    io_in = 1'b1;
  endtask

  task automatic read_status();
    status_rd = 1'b1;
    tick(1);
    status_rd = 1'b0;
    tick(1);
  endtask

  // toggle, start bit at edge k, then check outcome and clear
  task automatic trial(input string req, input int k);
    logic e;
    e = exp_hit(k);
    toggle_rst();
    tick(k);
    io_pulse();
    tick(5);
    chk(req, early_flag, e);
    chk("R4", irq_n, ~e);
    read_status();
    chk("R5", early_flag, 1'b0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    int k;
    void'($urandom(32'd20211));
    rst_n = 1'b0; card_rst = 1'b0; io_in = 1'b1; status_rd = 1'b0;
    tick(3);
    rst_n = 1'b1;
    tick(4);
    chk("R8", early_flag, 1'b0);
    chk("R8", irq_n, 1'b1);
    // no reset change yet: detector disarmed
    tick(250);
    io_pulse();
    tick(5);
    chk("R8", early_flag, 1'b0);

    trial("R2", 199);
    trial("R1", 200);
    trial("R1", 384);
    trial("R7", 385);

    // blanking edge does not disarm
    toggle_rst(); tick(150); io_pulse(); tick(97); io_pulse(); tick(5);
    chk("R2", early_flag, 1'b1);
    read_status();

    // only first start bit counts
    toggle_rst(); tick(210); io_pulse(); tick(2);
    chk("R1", early_flag, 1'b1);
    read_status();
    chk("R6", early_flag, 1'b0);
    tick(83); io_pulse(); tick(5);
    chk("R6", early_flag, 1'b0);

    // set and read at the same edge: set wins
    toggle_rst(); tick(250); io_in = 1'b0; tick(2);
    status_rd = 1'b1; tick(1); status_rd = 1'b0; io_in = 1'b1; tick(3);
    chk("R5", early_flag, 1'b1);
    chk("R4", irq_n, 1'b0);
    read_status();
    chk("R4", irq_n, 1'b1);

    // re-arm: second change restarts counting
    toggle_rst(); tick(300); toggle_rst(); tick(150); io_pulse(); tick(5);
    chk("R3", early_flag, 1'b0);
    toggle_rst(); tick(300); toggle_rst(); tick(210); io_pulse(); tick(5);
    chk("R3", early_flag, 1'b1);
    read_status();

    // very late edge, past a 9-bit wrap point
    toggle_rst(); tick(712); io_pulse(); tick(5);
    chk("R7", early_flag, 1'b0);

    // I/O held low across the change: no edge
    io_in = 1'b0; tick(5); toggle_rst(); tick(420);
    chk("R9", early_flag, 1'b0);
    io_in = 1'b1; tick(5);
    chk("R9", early_flag, 1'b0);

    for (int i = 0; i < 30; i++) begin
      k = 150 + int'($urandom_range(0, 300));
      trial("R1", k);
    end

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule